// File: doc/BRIEF.md
# Warp Issue Scheduler

This block picks, in every clock cycle, at most one warp out of a parameterised set of resident warps to issue its next instruction. A warp is a candidate only when it is resident, is not waiting on a memory access, and has no earlier result still in flight. Among the candidates, the one with the highest priority value wins. Candidates that share the top priority take turns in round-robin order, beginning with the warp after the one granted most recently. The block keeps two pieces of state per warp. The first is a small countdown of outstanding results, loaded on every grant. The second is a memory-wait flag, set when the granted instruction is a memory access and cleared by a response event that names the warp.

The surrounding pipeline drives a residency bit, a priority value and a "next instruction is a memory access" bit for each warp. It also delivers memory responses as a valid strobe plus a warp number. The grant leaves the block as a one-hot vector, an encoded warp number and an issue-valid strobe, all decided combinationally in the same cycle. A grant is always taken, so the issue side has no back-pressure. A response that clears a warp's memory-wait flag counts already in the cycle it arrives. Moving the grant from one warp to another therefore costs no idle cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no warp is waiting on memory or on a result, and the round-robin pointer points at the last warp. The first grant among equal-priority eligible warps therefore goes to warp 0. While no warp is resident, issue_valid is 0.
- R2: A warp is eligible exactly when all three hold: its resident bit is 1, its result countdown is zero, and it is not waiting on memory. issue_valid is 1 exactly when some warp is eligible. When issue_valid is 1, issue_grant has only bit issue_warp set. When issue_valid is 0, issue_grant is all zeros.
- R3: The granted warp has the largest priority value among the eligible warps, with a larger unsigned value meaning more urgent. Warp w's priority is warp_prio[w*PRIO_W +: PRIO_W].
- R4: Among eligible warps with the top priority, the grant goes to the first one found searching upward, with wrap-around, from the warp after the last granted warp.
- R5: A cycle with issue_valid low leaves the round-robin pointer unchanged.
- R6: A granted warp is not eligible in the BUSY_LAT cycles that follow its grant. It becomes eligible again in the cycle after those, provided nothing else holds it.
- R7: Granting a warp whose warp_next_mem bit is 1 makes that warp wait on memory. It stays ineligible until a cycle with resp_valid high and resp_warp equal to it. That warp can be granted within that same cycle.
- R8: When a warp is cleared by a response and granted with warp_next_mem high in the same cycle, it is again waiting on memory afterwards.
- R9: A response naming a warp that is not waiting on memory has no effect on it. In particular, it does not shorten the warp's result countdown.
- R10: Consecutive cycles may grant different warps with issue_valid high in each cycle, so no cycle is lost when the grant moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_resident | input | NUM_WARPS | Per-warp resident bit |
| warp_prio | input | NUM_WARPS*PRIO_W | Per-warp priority, warp w at bits w*PRIO_W +: PRIO_W |
| warp_next_mem | input | NUM_WARPS | Per-warp bit: next instruction is a memory access |
| resp_valid | input | 1 | Memory response event strobe |
| resp_warp | input | $clog2(NUM_WARPS) | Warp that the response belongs to |
| issue_valid | output | 1 | A warp is granted this cycle |
| issue_grant | output | NUM_WARPS | One-hot grant vector |
| issue_warp | output | $clog2(NUM_WARPS) | Number of the granted warp |

## Verification
A memory response for a warp and a new grant to that same warp can fall in one cycle, because the response counts already in the cycle it arrives. The collision is provoked by holding a single resident warp in the memory-wait state with warp_next_mem still high and then delivering its response. The warp must be granted in that cycle. It must then stay ungranted well past the result countdown, which shows that setting the wait flag wins over clearing it. The same overlap also shows up in the constrained random phase, where responses target warps that are waiting and that the priority picker may grant at once.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  // Next index after cur in a ring of n entries.
  function automatic int ring_next(input int cur, input int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/wsched_warp_state.sv
module wsched_warp_state #(
  parameter int NUM_WARPS = 8,
  parameter int BUSY_LAT  = 3,
  localparam int IDW = $clog2(NUM_WARPS),
  localparam int CW  = $clog2(BUSY_LAT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] resident,
  input  logic [NUM_WARPS-1:0] next_mem,
  input  logic [NUM_WARPS-1:0] grant,
  input  logic                 resp_valid,
  input  logic [IDW-1:0]       resp_warp,
  output logic [NUM_WARPS-1:0] elig
);

  localparam logic [CW-1:0] LOAD = CW'(BUSY_LAT);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic [CW-1:0] cnt_q;
    logic          mem_wait_q;
    logic          resp_hit;

    assign resp_hit = resp_valid && (resp_warp == IDW'(w));
    // A response releases the warp in the cycle it arrives.
    assign elig[w]  = resident[w] && (cnt_q == '0) && (!mem_wait_q || resp_hit);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q      <= '0;
        mem_wait_q <= 1'b0;
      end else begin
        if (grant[w])
          cnt_q <= LOAD;
        else if (cnt_q != '0)
          cnt_q <= cnt_q - 1'b1;

        // Setting on a memory grant wins over a same-cycle clear.
        if (grant[w] && next_mem[w])
          mem_wait_q <= 1'b1;
        else if (resp_hit)
          mem_wait_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wsched_pick.sv
module wsched_pick
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int PRIO_W    = 2,
  localparam int IDW = $clog2(NUM_WARPS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WARPS-1:0]        elig,
  input  logic [NUM_WARPS*PRIO_W-1:0] prio,
  output logic                        sel_valid,
  output logic [NUM_WARPS-1:0]        sel_onehot,
  output logic [IDW-1:0]              sel_idx,
  output logic [IDW-1:0]              rr_ptr
);

  logic [PRIO_W-1:0]    top_prio;
  logic [NUM_WARPS-1:0] cand;

  // Stage 1: largest priority among eligible warps.
  always_comb begin
    top_prio = '0;
    for (int i = 0; i < NUM_WARPS; i++)
      if (elig[i] && prio[i*PRIO_W +: PRIO_W] > top_prio)
        top_prio = prio[i*PRIO_W +: PRIO_W];
  end

  for (genvar i = 0; i < NUM_WARPS; i++) begin : g_cand
    assign cand[i] = elig[i] && (prio[i*PRIO_W +: PRIO_W] == top_prio);
  end

  // Stage 2: rotating search over the top-priority candidates.
  always_comb begin
    int idx;
    sel_valid = 1'b0;
    sel_idx   = '0;
    idx       = int'(rr_ptr);
    for (int k = 0; k < NUM_WARPS; k++) begin
      idx = ring_next(idx, NUM_WARPS);
      if (!sel_valid && cand[idx]) begin
        sel_valid = 1'b1;
        sel_idx   = IDW'(idx);
      end
    end
  end

  for (genvar i = 0; i < NUM_WARPS; i++) begin : g_onehot
    assign sel_onehot[i] = sel_valid && (sel_idx == IDW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rr_ptr <= IDW'(NUM_WARPS - 1);
    else if (sel_valid)
      rr_ptr <= sel_idx;
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 8,
  parameter int PRIO_W    = 2,
  parameter int BUSY_LAT  = 3,
  localparam int IDW = $clog2(NUM_WARPS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_WARPS-1:0]        warp_resident,
  input  logic [NUM_WARPS*PRIO_W-1:0] warp_prio,
  input  logic [NUM_WARPS-1:0]        warp_next_mem,
  input  logic                        resp_valid,
  input  logic [IDW-1:0]              resp_warp,
  output logic                        issue_valid,
  output logic [NUM_WARPS-1:0]        issue_grant,
  output logic [IDW-1:0]              issue_warp
);

  logic [NUM_WARPS-1:0] elig;
  logic [IDW-1:0]       rr_ptr;

  wsched_warp_state #(
    .NUM_WARPS(NUM_WARPS),
    .BUSY_LAT (BUSY_LAT)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .resident  (warp_resident),
    .next_mem  (warp_next_mem),
    .grant     (issue_grant),
    .resp_valid(resp_valid),
    .resp_warp (resp_warp),
    .elig      (elig)
  );

  wsched_pick #(
    .NUM_WARPS(NUM_WARPS),
    .PRIO_W   (PRIO_W)
  ) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .elig      (elig),
    .prio      (warp_prio),
    .sel_valid (issue_valid),
    .sel_onehot(issue_grant),
    .sel_idx   (issue_warp),
    .rr_ptr    (rr_ptr)
  );

endmodule

// File: rtl/wsched_checker.sv
module wsched_checker #(
  parameter int NUM_WARPS = 8,
  parameter int PRIO_W    = 2,
  localparam int IDW = $clog2(NUM_WARPS)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_WARPS-1:0]        warp_resident,
  input logic [NUM_WARPS*PRIO_W-1:0] warp_prio,
  input logic [NUM_WARPS-1:0]        warp_next_mem,
  input logic                        resp_valid,
  input logic [IDW-1:0]              resp_warp,
  input logic                        issue_valid,
  input logic [NUM_WARPS-1:0]        issue_grant,
  input logic [IDW-1:0]              issue_warp,
  input logic [NUM_WARPS-1:0]        elig,
  input logic [IDW-1:0]              rr_ptr
);

  logic           higher_exists;
  logic           last_mem_q;
  logic [IDW-1:0] last_w_q;

  always_comb begin
    higher_exists = 1'b0;
    for (int i = 0; i < NUM_WARPS; i++)
      if (elig[i] && warp_prio[i*PRIO_W +: PRIO_W] > warp_prio[issue_warp*PRIO_W +: PRIO_W])
        higher_exists = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_mem_q <= 1'b0;
      last_w_q   <= '0;
    end else begin
      last_mem_q <= issue_valid && warp_next_mem[issue_warp];
      last_w_q   <= issue_warp;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ($countones(issue_grant) == 1 && issue_grant[issue_warp]));
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (issue_grant == '0));
  a_r2_valid_iff_elig: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid == (|elig));
  a_r2_resident: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> warp_resident[issue_warp]);
  a_r3_top_prio: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !higher_exists);
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> $stable(rr_ptr));
  a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !(issue_valid && issue_warp == $past(issue_warp)));
  a_r7_mem_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (last_mem_q && !(resp_valid && resp_warp == last_w_q)) |-> !elig[last_w_q]);

endmodule

bind warp_issue_sched wsched_checker #(
  .NUM_WARPS(NUM_WARPS),
  .PRIO_W   (PRIO_W)
) u_wsched_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .warp_resident(warp_resident),
  .warp_prio    (warp_prio),
  .warp_next_mem(warp_next_mem),
  .resp_valid   (resp_valid),
  .resp_warp    (resp_warp),
  .issue_valid  (issue_valid),
  .issue_grant  (issue_grant),
  .issue_warp   (issue_warp),
  .elig         (elig),
  .rr_ptr       (rr_ptr)
);

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;
  localparam int N   = 8;
  localparam int PW  = 2;
  localparam int LAT = 3;
  localparam int IDW = $clog2(N);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    warp_resident;
  logic [N*PW-1:0] warp_prio;
  logic [N-1:0]    warp_next_mem;
  logic            resp_valid;
  logic [IDW-1:0]  resp_warp;
  logic            issue_valid;
  logic [N-1:0]    issue_grant;
  logic [IDW-1:0]  issue_warp;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference state built from the requirements.
  bit m_pend[N];
  int m_cnt[N];
  int m_ptr;

  always #5 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(N), .PRIO_W(PW), .BUSY_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .warp_resident(warp_resident), .warp_prio(warp_prio),
    .warp_next_mem(warp_next_mem), .resp_valid(resp_valid), .resp_warp(resp_warp),
    .issue_valid(issue_valid), .issue_grant(issue_grant), .issue_warp(issue_warp));

  function automatic int prio_of(int w);
    return int'(warp_prio[w*PW +: PW]);
  endfunction

  function automatic bit m_elig(int w);
    return warp_resident[w] && m_cnt[w] == 0 &&
           (!m_pend[w] || (resp_valid && int'(resp_warp) == w));
  endfunction

  task automatic model_pick(output bit v, output int w);
    int top = -1;
    v = 0; w = 0;
    for (int i = 0; i < N; i++)
      if (m_elig(i) && prio_of(i) > top) top = prio_of(i);
    for (int k = 1; k <= N; k++) begin
      int idx = (m_ptr + k) % N;
      if (!v && m_elig(idx) && prio_of(idx) == top) begin v = 1; w = idx; end
    end
  endtask

  task automatic model_update(bit v, int w);
    for (int i = 0; i < N; i++) begin
      bit hit = resp_valid && int'(resp_warp) == i;
      if (v && w == i) begin
        m_cnt[i] = LAT;
        m_pend[i] = warp_next_mem[i];
      end else begin
        if (m_cnt[i] > 0) m_cnt[i]--;
        if (hit) m_pend[i] = 0;
      end
    end
    if (v) m_ptr = w;
  endtask

  task automatic check(string tag, bit ok, string act, string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // One cycle: sample after inputs settle, compare, advance model, go to next negedge.
  task automatic cyc(string tag, bit lit, bit ev, int ew);
    bit xv; int xw;
    logic [N-1:0] xg;
    #1;
    model_pick(xv, xw);
    xg = xv ? (N'(1) << xw) : '0;
    check(tag, issue_valid == xv && issue_grant == xg && (!xv || int'(issue_warp) == xw),
          $sformatf("v=%0b w=%0d g=%b", issue_valid, issue_warp, issue_grant),
          $sformatf("v=%0b w=%0d g=%b", xv, xw, xg));
    if (lit)
      check(tag, issue_valid == ev && (!ev || int'(issue_warp) == ew),
            $sformatf("v=%0b w=%0d", issue_valid, issue_warp),
            $sformatf("v=%0b w=%0d", ev, ew));
    model_update(xv, xw);
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    warp_resident = '0; resp_valid = 0; warp_next_mem = '0;
    for (int i = 0; i < n; i++) cyc(tag, 1, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; warp_resident = '0; warp_prio = '0; warp_next_mem = '0;
    resp_valid = 0; resp_warp = '0;
    for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_cnt[i] = 0; end
    m_ptr = N - 1;
    repeat (3) @(negedge clk);
    #1 check("R1", issue_valid == 0 && issue_grant == '0,
             $sformatf("%0b", issue_valid), "0");
    @(negedge clk);
    rst_n = 1;

    // R1: nothing resident, then first grant goes to warp 0
    cyc("R1", 1, 0, 0);
    warp_resident = '1;
    cyc("R1", 1, 1, 0);
    // R10 / R4: grant walks through the warps with no lost cycle
    for (int i = 1; i < N; i++) cyc("R10", 1, 1, i);
    cyc("R4", 1, 1, 0);
    // R5: idle cycles keep the pointer
    idle("R5", 4);
    warp_resident = '1;
    cyc("R5", 1, 1, 1);
    // R3: higher priority wins over round-robin order
    warp_prio[5*PW +: PW] = 2'd3;
    cyc("R3", 1, 1, 5);
    cyc("R4", 1, 1, 6);
    warp_prio = '0;
    idle("R6", 4);
    // R6: single warp busy for LAT cycles
    warp_resident = 8'b0000_0100;
    cyc("R6", 1, 1, 2);
    for (int i = 0; i < LAT; i++) cyc("R6", 1, 0, 0);
    cyc("R6", 1, 1, 2);
    idle("R7", 4);
    // R7: memory grant blocks until response; same-cycle release
    warp_resident = 8'b0000_1000; warp_next_mem = 8'b0000_1000;
    cyc("R7", 1, 1, 3);
    for (int i = 0; i < LAT + 3; i++) cyc("R7", 1, 0, 0);
    resp_valid = 1; resp_warp = 3'd3;
    cyc("R7", 1, 1, 3);
    resp_valid = 0;
    // R8: re-granted with a memory op in the response cycle, so it waits again
    for (int i = 0; i < LAT + 3; i++) cyc("R8", 1, 0, 0);
    warp_next_mem = '0; resp_valid = 1;
    cyc("R7", 1, 1, 3);
    resp_valid = 0;
    for (int i = 0; i < LAT; i++) cyc("R6", 1, 0, 0);
    cyc("R6", 1, 1, 3);
    idle("R9", 4);
    // R9: response to a non-waiting warp leaves its countdown intact
    warp_resident = 8'b0000_0010;
    cyc("R9", 1, 1, 1);
    resp_valid = 1; resp_warp = 3'd1;
    cyc("R9", 1, 0, 0);
    resp_valid = 0;
    cyc("R9", 1, 0, 0);
    cyc("R9", 1, 0, 0);
    cyc("R9", 1, 1, 1);

    // Constrained random phase
    for (int t = 0; t < 4000; t++) begin
      for (int i = 0; i < N; i++) begin
        warp_resident[i] = ($urandom % 8) != 0;
        warp_next_mem[i] = ($urandom % 4) == 0;
        warp_prio[i*PW +: PW] = PW'($urandom % 4);
      end
      resp_valid = ($urandom % 3) == 0;
      resp_warp  = IDW'($urandom % N);
      if (resp_valid && ($urandom % 2) == 0)
        for (int i = 0; i < N; i++) if (m_pend[i]) resp_warp = IDW'(i);
      cyc("R2", 0, 0, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule